// File: doc/BRIEF.md
# I2C Line Conditioner with Stuck-Bus Watchdog

This block sits between the raw I2C pads and the protocol engine of an I2C target. It brings SCL and SDA into the system clock domain with two-stage synchronizers. A counter-based filter then drops any pulse shorter than a programmable number of system clocks. From the cleaned lines it produces one-cycle strobes for each SCL rising and falling edge. It also produces strobes for START, repeated START and STOP conditions. After each SCL falling edge, the SDA seen by the engine is frozen for a short window. This bridges the slow, undefined part of the clock fall.

A watchdog counts while either cleaned line is low. The count restarts whenever both lines are high. When the count reaches its limit, the block sends one bus-reset pulse to the protocol engine. It sends no further pulse until both lines have been high again. An enable input switches the watchdog off so the bus can be held static. Because of this watchdog, an SCL phase longer than the limit is treated as a fault, not as a slow clock. The limit therefore sets the lowest usable SCL rate. With the default parameters at a 100 MHz clock, the filter rejects pulses under 50 ns, the SDA hold lasts 300 ns and the watchdog limit is 25 ms. These settings support standard, fast and fast-plus rates, so conditions only 0.26 µs apart are still resolved.

Top module: `i2c_in_cond`

## Requirements
- R1: A pulse on raw SCL or raw SDA lasting fewer than FILT_CYCLES system clocks never changes sclOut or sdaOut and produces no edge or condition strobe.
- R2: After reset, sclOut and sdaOut are 1 and every strobe and busRst are 0. A raw level held for FILT_CYCLES clocks or more reaches the filtered output.
- R3: sclRise (sclFall) is high for exactly the one cycle in which sclOut has just changed from 0 to 1 (from 1 to 0).
- R4: A fall of sdaOut while sclOut stays high, with no transaction open, gives one startPulse and opens a transaction.
- R5: A fall of sdaOut while sclOut stays high, with a transaction already open, gives one rptStartPulse and no startPulse. The two strobes and stopPulse are never high together.
- R6: A rise of sdaOut while sclOut stays high gives one stopPulse and closes the transaction, so the next START is reported as a plain START.
- R7: After sclOut falls, sdaOut keeps its value. A change that the filtered SDA makes in that window appears on sdaOut exactly HOLD_CYCLES+1 clocks after the cycle in which sclOut fell.
- R8: With timeoutEn high, either filtered line being low for at least TIMEOUT_CYCLES clocks gives exactly one one-cycle busRst. The bus reset also closes any open transaction.
- R9: The watchdog count restarts whenever both filtered lines are high. After a busRst, no further busRst occurs until both lines have been high again.
- R10: While timeoutEn is low, busRst never goes high, however long a line stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sclRaw | input | 1 | Raw SCL from the pad |
| sdaRaw | input | 1 | Raw SDA from the pad |
| timeoutEn | input | 1 | Enables the stuck-low watchdog |
| sclOut | output | 1 | Filtered SCL |
| sdaOut | output | 1 | Filtered SDA, with the hold window applied |
| sclRise | output | 1 | One-cycle strobe on an SCL rising edge |
| sclFall | output | 1 | One-cycle strobe on an SCL falling edge |
| startPulse | output | 1 | One-cycle strobe on a START with no open transaction |
| rptStartPulse | output | 1 | One-cycle strobe on a repeated START |
| stopPulse | output | 1 | One-cycle strobe on a STOP |
| busRst | output | 1 | One-cycle reset pulse to the protocol engine on a stuck bus |

## Verification
The assertions assume the bus behaves like a legal I2C bus after filtering. Outside START and STOP, SDA changes only while SCL is low. No filtered SDA edge falls within the hold window together with an SCL rise. The stimulus follows these rules by letting each raw level settle for many times FILT_CYCLES before the other line moves. Every SDA change made with SCL low waits longer than the hold window before SCL rises. The only deliberately short pulses are the glitches used to test rejection.

// File: rtl/i2c_in_cond_pkg.sv
package i2c_in_cond_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic holdStart;  // filtered SCL has just fallen: freeze SDA
    logic toClear;    // restart the stuck-low counter
  } ctrl2dp_t;

  // state from datapath to control
  typedef struct packed {
    logic sclF;       // filtered SCL
    logic sdaH;       // filtered SDA after the hold window
    logic toHit;      // stuck-low counter has reached its limit
  } dp2ctrl_t;

endpackage

// File: rtl/i2c_glitch_filter.sv
module i2c_glitch_filter #(
  parameter int CYCLES = 5
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [1:0]    syncQ;
  logic [CW-1:0] runCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ  <= 2'b11;
      runCnt <= '0;
      dout   <= 1'b1;
    end else begin
      syncQ <= {syncQ[0], din};
      if (syncQ[1] == dout) begin
        runCnt <= '0;
      end else if (runCnt == CW'(CYCLES - 1)) begin
        dout   <= syncQ[1];
        runCnt <= '0;
      end else begin
        runCnt <= runCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_cond_dp.sv
module i2c_cond_dp
  import i2c_in_cond_pkg::*;
#(
  parameter int FILT_CYCLES    = 5,
  parameter int HOLD_CYCLES    = 30,
  parameter int TIMEOUT_CYCLES = 2500000
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     sclRaw,
  input  logic     sdaRaw,
  input  ctrl2dp_t ctl,
  output dp2ctrl_t st
);
  localparam int HW = $clog2(HOLD_CYCLES + 1);
  localparam int TW = $clog2(TIMEOUT_CYCLES + 1);

  logic [1:0]    rawVec;
  logic [1:0]    filtVec;
  logic [HW-1:0] holdCnt;
  logic          sdaHeld;
  logic [TW-1:0] toCnt;

  assign rawVec = {sdaRaw, sclRaw};

  // one filter per line: bit 0 is SCL, bit 1 is SDA
  for (genvar i = 0; i < 2; i++) begin : g_line
    i2c_glitch_filter #(.CYCLES(FILT_CYCLES)) filt_i (
      .clk (clk),
      .rstN(rstN),
      .din (rawVec[i]),
      .dout(filtVec[i])
    );
  end

  // SDA hold window after each SCL fall
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt <= '0;
      sdaHeld <= 1'b1;
    end else begin
      if (ctl.holdStart) begin
        holdCnt <= HW'(HOLD_CYCLES - 1);
      end else if (holdCnt != '0) begin
        holdCnt <= holdCnt - 1'b1;
      end
      if (!ctl.holdStart && holdCnt == '0) begin
        sdaHeld <= filtVec[1];
      end
    end
  end

  // stuck-low counter, saturating at its limit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      toCnt <= '0;
    end else if (ctl.toClear) begin
      toCnt <= '0;
    end else if (toCnt != TW'(TIMEOUT_CYCLES - 1)) begin
      toCnt <= toCnt + 1'b1;
    end
  end

  assign st.sclF  = filtVec[0];
  assign st.sdaH  = sdaHeld;
  assign st.toHit = (toCnt == TW'(TIMEOUT_CYCLES - 1));
endmodule

// File: rtl/i2c_cond_ctrl.sv
module i2c_cond_ctrl
  import i2c_in_cond_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     timeoutEn,
  input  dp2ctrl_t st,
  output ctrl2dp_t ctl,
  output logic     sclRise,
  output logic     sclFall,
  output logic     startPulse,
  output logic     rptStartPulse,
  output logic     stopPulse,
  output logic     busRst
);
  logic sclPrev;
  logic sdaPrev;
  logic busy;
  logic armed;
  logic anyStart;
  logic fireNow;

  always_comb begin
    sclRise       = st.sclF & ~sclPrev;
    sclFall       = ~st.sclF & sclPrev;
    anyStart      = st.sclF & sclPrev & sdaPrev & ~st.sdaH;
    stopPulse     = st.sclF & sclPrev & ~sdaPrev & st.sdaH;
    startPulse    = anyStart & ~busy;
    rptStartPulse = anyStart & busy;
    ctl.holdStart = sclFall;
    ctl.toClear   = ~timeoutEn | (st.sclF & st.sdaH);
    fireNow       = armed & st.toHit & timeoutEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
      busy    <= 1'b0;
      armed   <= 1'b1;
      busRst  <= 1'b0;
    end else begin
      sclPrev <= st.sclF;
      sdaPrev <= st.sdaH;
      busRst  <= fireNow;
      if (fireNow || stopPulse) begin
        busy <= 1'b0;
      end else if (anyStart) begin
        busy <= 1'b1;
      end
      if (fireNow) begin
        armed <= 1'b0;
      end else if (st.sclF && st.sdaH) begin
        armed <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_in_cond.sv
module i2c_in_cond
  import i2c_in_cond_pkg::*;
#(
  parameter int FILT_CYCLES    = 5,
  parameter int HOLD_CYCLES    = 30,
  parameter int TIMEOUT_CYCLES = 2500000
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclRaw,
  input  logic sdaRaw,
  input  logic timeoutEn,
  output logic sclOut,
  output logic sdaOut,
  output logic sclRise,
  output logic sclFall,
  output logic startPulse,
  output logic rptStartPulse,
  output logic stopPulse,
  output logic busRst
);
  ctrl2dp_t ctl;
  dp2ctrl_t st;

  i2c_cond_dp #(
    .FILT_CYCLES   (FILT_CYCLES),
    .HOLD_CYCLES   (HOLD_CYCLES),
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
  ) dp_i (
    .clk   (clk),
    .rstN  (rstN),
    .sclRaw(sclRaw),
    .sdaRaw(sdaRaw),
    .ctl   (ctl),
    .st    (st)
  );

  i2c_cond_ctrl ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .timeoutEn    (timeoutEn),
    .st           (st),
    .ctl          (ctl),
    .sclRise      (sclRise),
    .sclFall      (sclFall),
    .startPulse   (startPulse),
    .rptStartPulse(rptStartPulse),
    .stopPulse    (stopPulse),
    .busRst       (busRst)
  );

  assign sclOut = st.sclF;
  assign sdaOut = st.sdaH;
endmodule

// File: rtl/i2c_in_cond_checker.sv
module i2c_in_cond_checker (
  input logic clk,
  input logic rstN,
  input logic sclRaw,
  input logic sdaRaw,
  input logic timeoutEn,
  input logic sclOut,
  input logic sdaOut,
  input logic sclRise,
  input logic sclFall,
  input logic startPulse,
  input logic rptStartPulse,
  input logic stopPulse,
  input logic busRst
);
  assert_edge_rise_R3: assert property (@(posedge clk) disable iff (!rstN)
    sclRise |-> (sclOut && !$past(sclOut)));

  assert_edge_fall_R3: assert property (@(posedge clk) disable iff (!rstN)
    sclFall |-> (!sclOut && $past(sclOut)));

  assert_cond_scl_high_R4: assert property (@(posedge clk) disable iff (!rstN)
    (startPulse || rptStartPulse || stopPulse) |-> (sclOut && $past(sclOut)));

  assert_start_exclusive_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({startPulse, rptStartPulse, stopPulse}));

  assert_stop_sda_rise_R6: assert property (@(posedge clk) disable iff (!rstN)
    stopPulse |-> (sdaOut && !$past(sdaOut)));

  assert_sda_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sclOut) |=> $stable(sdaOut));

  assert_busrst_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    busRst |=> !busRst);

  assert_busrst_disabled_R10: assert property (@(posedge clk) disable iff (!rstN)
    !$past(timeoutEn) |-> !busRst);
endmodule

bind i2c_in_cond i2c_in_cond_checker chk_i (.*);

// File: tb/i2c_in_cond_tb_top.sv
module i2c_in_cond_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int FILT = 4;
  localparam int HOLD = 12;
  localparam int TO   = 300;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclRaw = 1'b1;
  logic sdaRaw = 1'b1;
  logic timeoutEn = 1'b1;
  logic sclOut, sdaOut, sclRise, sclFall;
  logic startPulse, rptStartPulse, stopPulse, busRst;

  int nRun = 0;
  int nFail = 0;
  bit finished = 1'b0;

  // pulse counters sampled at the falling edge
  int cyc = 0;
  int nRise = 0, nFall = 0, nStart = 0, nRpt = 0, nStop = 0, nRst = 0, nSdaLow = 0, nSclLow = 0;
  int tSclFall = 0, tSdaFall = 0;
  logic sdaOutPrev = 1'b1;

  always #(CLK_PERIOD / 2) clk = ~clk;

  i2c_in_cond #(
    .FILT_CYCLES(FILT), .HOLD_CYCLES(HOLD), .TIMEOUT_CYCLES(TO)
  ) dut_i (
    .clk(clk), .rstN(rstN), .sclRaw(sclRaw), .sdaRaw(sdaRaw), .timeoutEn(timeoutEn),
    .sclOut(sclOut), .sdaOut(sdaOut), .sclRise(sclRise), .sclFall(sclFall),
    .startPulse(startPulse), .rptStartPulse(rptStartPulse), .stopPulse(stopPulse),
    .busRst(busRst)
  );

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rstN) begin
      nRise   = nRise + int'(sclRise);
      nFall   = nFall + int'(sclFall);
      nStart  = nStart + int'(startPulse);
      nRpt    = nRpt + int'(rptStartPulse);
      nStop   = nStop + int'(stopPulse);
      nRst    = nRst + int'(busRst);
      nSdaLow = nSdaLow + int'(!sdaOut);
      nSclLow = nSclLow + int'(!sclOut);
      if (sclFall) tSclFall = cyc;
      if (sdaOutPrev && !sdaOut) tSdaFall = cyc;
      sdaOutPrev = sdaOut;
    end
  end

  task automatic waitCyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic testReset();
    waitCyc(2);
    check(sclOut == 1'b1, "R2 reset sclOut", int'(sclOut), 1);
    check(sdaOut == 1'b1, "R2 reset sdaOut", int'(sdaOut), 1);
    check(nRise + nFall + nStart + nRpt + nStop + nRst == 0, "R2 reset strobes",
          nRise + nFall + nStart + nRpt + nStop + nRst, 0);
  endtask

  task automatic testGlitch();
    int f0 = nFall, r0 = nRise, l0 = nSclLow, s0 = nSdaLow, st0 = nStart;
    sclRaw = 1'b0; waitCyc(FILT - 1); sclRaw = 1'b1; waitCyc(20);
    sdaRaw = 1'b0; waitCyc(FILT - 1); sdaRaw = 1'b1; waitCyc(20);
    check(nSclLow == l0, "R1 scl glitch level", nSclLow - l0, 0);
    check(nFall == f0 && nRise == r0, "R1 scl glitch edges", nFall - f0 + nRise - r0, 0);
    check(nSdaLow == s0 && nStart == st0, "R1 sda glitch", nSdaLow - s0 + nStart - st0, 0);
  endtask

  task automatic testAccept();
    int f0 = nFall, r0 = nRise, c0 = nStart + nRpt + nStop;
    sclRaw = 1'b0; waitCyc(FILT + 6);
    check(sclOut == 1'b0, "R2 long low passes", int'(sclOut), 0);
    sclRaw = 1'b1; waitCyc(20);
    check(nFall - f0 == 1, "R3 one fall strobe", nFall - f0, 1);
    check(nRise - r0 == 1, "R3 one rise strobe", nRise - r0, 1);
    check(nStart + nRpt + nStop == c0, "R3 no condition on scl toggle", nStart + nRpt + nStop - c0, 0);
  endtask

  task automatic testStart();
    int s0 = nStart, p0 = nRpt;
    sdaRaw = 1'b0; waitCyc(20);
    check(nStart - s0 == 1, "R4 start pulse", nStart - s0, 1);
    check(nRpt == p0, "R4 no repeated flag", nRpt - p0, 0);
  endtask

  task automatic testRptStart();
    int s0 = nStart, p0 = nRpt;
    sclRaw = 1'b0; waitCyc(30);
    sdaRaw = 1'b1; waitCyc(30);
    sclRaw = 1'b1; waitCyc(20);
    sdaRaw = 1'b0; waitCyc(20);
    check(nRpt - p0 == 1, "R5 repeated start pulse", nRpt - p0, 1);
    check(nStart == s0, "R5 no plain start", nStart - s0, 0);
  endtask

  task automatic testStop();
    int p0 = nStop, s0 = nStart, r0 = nRpt;
    sclRaw = 1'b0; waitCyc(30);
    sclRaw = 1'b1; waitCyc(20);
    sdaRaw = 1'b1; waitCyc(20);
    check(nStop - p0 == 1, "R6 stop pulse", nStop - p0, 1);
    sdaRaw = 1'b0; waitCyc(20);
    check(nStart - s0 == 1 && nRpt == r0, "R6 start after stop is plain", nStart - s0, 1);
    sdaRaw = 1'b1; waitCyc(20);
  endtask

  task automatic testHold();
    int s0 = nStart, p0 = nRpt;
    sclRaw = 1'b0; waitCyc(1);
    sdaRaw = 1'b0; waitCyc(HOLD + 20);
    check(tSdaFall - tSclFall == HOLD + 1, "R7 sda hold delay", tSdaFall - tSclFall, HOLD + 1);
    check(nStart == s0 && nRpt == p0, "R7 no false start", nStart - s0 + nRpt - p0, 0);
    sdaRaw = 1'b1; waitCyc(30);
    sclRaw = 1'b1; waitCyc(20);
  endtask

  task automatic testTimeout();
    int b0 = nRst;
    sclRaw = 1'b0; waitCyc(TO + 100);
    check(nRst - b0 == 1, "R8 single bus reset", nRst - b0, 1);
    waitCyc(TO + 100);
    check(nRst - b0 == 1, "R9 no rearm while low", nRst - b0, 1);
    sclRaw = 1'b1; waitCyc(30);
    sclRaw = 1'b0; waitCyc(TO + 100);
    check(nRst - b0 == 2, "R9 rearm after idle", nRst - b0, 2);
    sclRaw = 1'b1; waitCyc(30);
  endtask

  task automatic testRestart();
    int b0 = nRst;
    sclRaw = 1'b0; waitCyc(TO - 80);
    sclRaw = 1'b1; waitCyc(30);
    sclRaw = 1'b0; waitCyc(TO - 80);
    sclRaw = 1'b1; waitCyc(30);
    check(nRst == b0, "R9 counter restarts on idle", nRst - b0, 0);
  endtask

  task automatic testDisabled();
    int b0 = nRst;
    timeoutEn = 1'b0;
    sdaRaw = 1'b0; waitCyc(20);
    sclRaw = 1'b0; waitCyc(3 * TO);
    check(nRst == b0, "R10 disabled never fires", nRst - b0, 0);
    sdaRaw = 1'b1; waitCyc(30);
    sclRaw = 1'b1; waitCyc(30);
    timeoutEn = 1'b1; waitCyc(5);
  endtask

  task automatic testRstClears();
    int b0 = nRst, s0, p0;
    sdaRaw = 1'b0; waitCyc(20);
    sclRaw = 1'b0; waitCyc(30);
    sdaRaw = 1'b1; waitCyc(TO + 100);
    check(nRst - b0 == 1, "R8 bus reset in transaction", nRst - b0, 1);
    sclRaw = 1'b1; waitCyc(30);
    s0 = nStart; p0 = nRpt;
    sdaRaw = 1'b0; waitCyc(20);
    check(nStart - s0 == 1 && nRpt == p0, "R8 bus reset closes transaction", nStart - s0, 1);
    sdaRaw = 1'b1; waitCyc(20);
  endtask

  initial begin
    waitCyc(5);
    rstN = 1'b1;
    testReset();
    testGlitch();
    testAccept();
    testStart();
    testRptStart();
    testStop();
    testHold();
    testTimeout();
    testRestart();
    testDisabled();
    testRstClears();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1'b1;
      nRun++;
      nFail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule